// File: doc/BRIEF.md
# Branch Condition and Cycle Evaluator

This combinational block decides the outcome of one control-transfer instruction for a small 8-bit processor. The decoder gives the branch kind, an optional condition and the operands: the address of the next instruction, a signed byte offset, a 16-bit immediate, the HL register, the word just read from the stack, a restart index and the stack pointer. The evaluator checks the condition against the zero and carry flags. It returns whether control moves, the next program counter and the number of clock states the instruction uses. It also returns the stack and interrupt-enable requests that the sequencer must carry out.

The block does not touch memory. The word to be pushed is the program counter. The popped word is taken from `stack_data_i`, and the block's only job with it is to choose it as the target. When a branch is not taken, the block requests nothing and passes the next-instruction address through unchanged.

Top module: `branch_eval`

## Requirements
- R1: With `cond_en_i`=1 on kinds 0..3, the branch is taken only if its condition holds: `cond_i` 0 means Z clear, 1 means Z set, 2 means C clear, 3 means C set. With `cond_en_i`=0 these kinds are always taken.
- R2: Kind 0 (absolute jump) targets `imm_i` and takes 16 states when taken and 12 when not taken.
- R3: Kind 1 (relative jump) targets `pc_i` plus the sign-extended `disp_i`, wrapping modulo 2^16. It takes 12 states when taken and 8 when not taken.
- R4: Kind 2 (call) targets `imm_i` and takes 24 states when taken and 12 when not taken. When taken it asserts `push_o`, and `sp_next_o` = `sp_i` - 2.
- R5: Kind 3 (return) targets `stack_data_i`. It takes 16 states when unconditional, and 20 states taken or 8 states not taken when conditional. When taken it asserts `pop_o`, and `sp_next_o` = `sp_i` + 2.
- R6: Kind 4 (return from interrupt) is always taken, whatever `cond_en_i` is. It acts as an unconditional return (16 states, pop, +2) and also asserts `ime_set_o`.
- R7: Kind 5 (restart) is always taken and targets `rst_idx_i`*8, which is one of 0x00..0x38. It takes 16 states, asserts `push_o`, and `sp_next_o` = `sp_i` - 2.
- R8: Kind 6 (register jump) is always taken, targets `hl_i` and takes 4 states with no stack request.
- R9: A not-taken branch outputs `target_o` = `pc_i` and `sp_next_o` = `sp_i`, with `push_o`, `pop_o` and `ime_set_o` all low. `push_o` and `pop_o` are never high together.
- R10: Kind 7 is reserved. It is never taken, reports 4 states and requests nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| kind_i | input | 3 | Branch kind code |
| cond_en_i | input | 1 | Conditional form select |
| cond_i | input | 2 | Condition code |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| pc_i | input | 16 | Address of the byte after the instruction |
| disp_i | input | 8 | Signed relative offset |
| imm_i | input | 16 | Immediate address |
| hl_i | input | 16 | HL register value |
| stack_data_i | input | 16 | Word popped from the stack |
| rst_idx_i | input | 3 | Restart vector index |
| sp_i | input | 16 | Current stack pointer |
| taken_o | output | 1 | Control moves to target |
| target_o | output | 16 | Next program counter |
| cycles_o | output | 5 | Clock states used |
| push_o | output | 1 | Push program counter request |
| pop_o | output | 1 | Pop program counter request |
| ime_set_o | output | 1 | Set interrupt master enable |
| sp_next_o | output | 16 | Updated stack pointer |

## Verification
The bench sweeps every kind code against both forms, all four condition codes and all four Z/C flag pairs. This shows whether the condition decode keeps zero and carry apart and keeps set apart from clear, and whether the unconditional kinds really ignore the condition inputs. Random operands then separate the immediate, HL, stack-word and restart-vector target paths. Directed offsets at 0x7F and 0x80 around addresses 0x0000 and 0xFFFF test sign extension and 16-bit wrap. Restart indices 0 and 7 test the vector end points.

// File: rtl/bce_pkg.sv
package bce_pkg;
  typedef enum logic [2:0] {
    BK_JP   = 3'd0,
    BK_JR   = 3'd1,
    BK_CALL = 3'd2,
    BK_RET  = 3'd3,
    BK_RETI = 3'd4,
    BK_RST  = 3'd5,
    BK_JPHL = 3'd6,
    BK_RSVD = 3'd7
  } br_kind_e;

  typedef enum logic [1:0] {
    CC_NZ = 2'd0,
    CC_Z  = 2'd1,
    CC_NC = 2'd2,
    CC_C  = 2'd3
  } cond_e;

  localparam int CYC_W = 5;
  typedef logic [CYC_W-1:0] cyc_t;

  localparam cyc_t CYC_JP_T   = 5'd16;
  localparam cyc_t CYC_JP_N   = 5'd12;
  localparam cyc_t CYC_JR_T   = 5'd12;
  localparam cyc_t CYC_JR_N   = 5'd8;
  localparam cyc_t CYC_CALL_T = 5'd24;
  localparam cyc_t CYC_CALL_N = 5'd12;
  localparam cyc_t CYC_RET_U  = 5'd16;
  localparam cyc_t CYC_RET_T  = 5'd20;
  localparam cyc_t CYC_RET_N  = 5'd8;
  localparam cyc_t CYC_RETI   = 5'd16;
  localparam cyc_t CYC_RST    = 5'd16;
  localparam cyc_t CYC_JPHL   = 5'd4;
  localparam cyc_t CYC_RSVD   = 5'd4;
endpackage

// File: rtl/bce_cond.sv
module bce_cond
  import bce_pkg::*;
(
  input  br_kind_e   kind_i,
  input  logic       cond_en_i,
  input  logic [1:0] cond_i,
  input  logic       flag_z_i,
  input  logic       flag_c_i,
  output logic       taken_o
);
  logic cond_met;
  logic cond_form;

  always_comb begin
    unique case (cond_e'(cond_i))
      CC_NZ:   cond_met = ~flag_z_i;
      CC_Z:    cond_met = flag_z_i;
      CC_NC:   cond_met = ~flag_c_i;
      default: cond_met = flag_c_i;
    endcase
  end

  // only the first four kinds have a conditional form
  assign cond_form = cond_en_i &&
                     (kind_i inside {BK_JP, BK_JR, BK_CALL, BK_RET});

  always_comb begin
    if (kind_i == BK_RSVD) taken_o = 1'b0;
    else if (cond_form)    taken_o = cond_met;
    else                   taken_o = 1'b1;
  end
endmodule

// File: rtl/bce_target.sv
module bce_target
  import bce_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DISP_W    = 8,
  parameter int RST_W     = 3,
  parameter int RST_SHIFT = 3
) (
  input  br_kind_e          kind_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [ADDR_W-1:0] stk_i,
  input  logic [RST_W-1:0]  rst_idx_i,
  output logic [ADDR_W-1:0] target_o
);
  localparam int EXT_W = ADDR_W - DISP_W;
  localparam int PAD_W = ADDR_W - RST_W - RST_SHIFT;

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] rel_tgt;
  logic [ADDR_W-1:0] rst_vec;

  generate
    if (EXT_W > 0) begin : g_sext
      assign disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
    end else begin : g_trunc
      assign disp_ext = disp_i[ADDR_W-1:0];
    end
    if (PAD_W > 0) begin : g_vec_pad
      assign rst_vec = {{PAD_W{1'b0}}, rst_idx_i, {RST_SHIFT{1'b0}}};
    end else begin : g_vec_nopad
      assign rst_vec = {rst_idx_i, {RST_SHIFT{1'b0}}};
    end
  endgenerate

  // carry out of the top bit is dropped: address wraps
  assign rel_tgt = pc_i + disp_ext;

  always_comb begin
    target_o = pc_i;
    if (taken_i) begin
      unique case (kind_i)
        BK_JP, BK_CALL:  target_o = imm_i;
        BK_JR:           target_o = rel_tgt;
        BK_RET, BK_RETI: target_o = stk_i;
        BK_RST:          target_o = rst_vec;
        BK_JPHL:         target_o = hl_i;
        default:         target_o = pc_i;
      endcase
    end
  end
endmodule

// File: rtl/bce_cycles.sv
module bce_cycles
  import bce_pkg::*;
(
  input  br_kind_e kind_i,
  input  logic     cond_en_i,
  input  logic     taken_i,
  output cyc_t     cycles_o
);
  always_comb begin
    unique case (kind_i)
      BK_JP:   cycles_o = taken_i ? CYC_JP_T : CYC_JP_N;
      BK_JR:   cycles_o = taken_i ? CYC_JR_T : CYC_JR_N;
      BK_CALL: cycles_o = taken_i ? CYC_CALL_T : CYC_CALL_N;
      BK_RET: begin
        if (!cond_en_i)   cycles_o = CYC_RET_U;
        else if (taken_i) cycles_o = CYC_RET_T;
        else              cycles_o = CYC_RET_N;
      end
      BK_RETI: cycles_o = CYC_RETI;
      BK_RST:  cycles_o = CYC_RST;
      BK_JPHL: cycles_o = CYC_JPHL;
      default: cycles_o = CYC_RSVD;
    endcase
  end
endmodule

// File: rtl/bce_stack.sv
module bce_stack
  import bce_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int SP_STEP = 2
) (
  input  br_kind_e          kind_i,
  input  logic              taken_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              push_o,
  output logic              pop_o,
  output logic              ime_set_o,
  output logic [ADDR_W-1:0] sp_next_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(SP_STEP);

  assign push_o    = taken_i && (kind_i inside {BK_CALL, BK_RST});
  assign pop_o     = taken_i && (kind_i inside {BK_RET, BK_RETI});
  assign ime_set_o = taken_i && (kind_i == BK_RETI);

  always_comb begin
    if (push_o)     sp_next_o = sp_i - STEP;
    else if (pop_o) sp_next_o = sp_i + STEP;
    else            sp_next_o = sp_i;
  end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import bce_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DISP_W    = 8,
  parameter int RST_W     = 3,
  parameter int RST_SHIFT = 3,
  parameter int SP_STEP   = 2
) (
  input  logic [2:0]        kind_i,
  input  logic              cond_en_i,
  input  logic [1:0]        cond_i,
  input  logic              flag_z_i,
  input  logic              flag_c_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] hl_i,
  input  logic [ADDR_W-1:0] stack_data_i,
  input  logic [RST_W-1:0]  rst_idx_i,
  input  logic [ADDR_W-1:0] sp_i,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o,
  output logic [CYC_W-1:0]  cycles_o,
  output logic              push_o,
  output logic              pop_o,
  output logic              ime_set_o,
  output logic [ADDR_W-1:0] sp_next_o
);
  br_kind_e kind;
  logic     taken;

  assign kind = br_kind_e'(kind_i);

  bce_cond u_cond (
    .kind_i   (kind),
    .cond_en_i(cond_en_i),
    .cond_i   (cond_i),
    .flag_z_i (flag_z_i),
    .flag_c_i (flag_c_i),
    .taken_o  (taken)
  );

  bce_target #(
    .ADDR_W   (ADDR_W),
    .DISP_W   (DISP_W),
    .RST_W    (RST_W),
    .RST_SHIFT(RST_SHIFT)
  ) u_target (
    .kind_i   (kind),
    .taken_i  (taken),
    .pc_i     (pc_i),
    .disp_i   (disp_i),
    .imm_i    (imm_i),
    .hl_i     (hl_i),
    .stk_i    (stack_data_i),
    .rst_idx_i(rst_idx_i),
    .target_o (target_o)
  );

  bce_cycles u_cycles (
    .kind_i   (kind),
    .cond_en_i(cond_en_i),
    .taken_i  (taken),
    .cycles_o (cycles_o)
  );

  bce_stack #(
    .ADDR_W (ADDR_W),
    .SP_STEP(SP_STEP)
  ) u_stack (
    .kind_i   (kind),
    .taken_i  (taken),
    .sp_i     (sp_i),
    .push_o   (push_o),
    .pop_o    (pop_o),
    .ime_set_o(ime_set_o),
    .sp_next_o(sp_next_o)
  );

  assign taken_o = taken;
endmodule

// File: rtl/branch_eval_chk.sv
module branch_eval_chk #(
  parameter int ADDR_W = 16,
  parameter int RST_W  = 3
) (
  input logic [2:0]        kind_i,
  input logic [ADDR_W-1:0] pc_i,
  input logic [ADDR_W-1:0] hl_i,
  input logic [ADDR_W-1:0] sp_i,
  input logic              taken_o,
  input logic [ADDR_W-1:0] target_o,
  input logic [4:0]        cycles_o,
  input logic              push_o,
  input logic              pop_o,
  input logic              ime_set_o,
  input logic [ADDR_W-1:0] sp_next_o
);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);
  localparam int VEC_W = RST_W + 3;

  logic known;
  assign known = !$isunknown({kind_i, pc_i, hl_i, sp_i, taken_o, target_o,
                              cycles_o, push_o, pop_o, ime_set_o, sp_next_o});

  always_comb begin
    if (known) begin
      assert_push_pop_excl_R9: assert (!(push_o && pop_o));
      assert_idle_not_taken_R9: assert (taken_o ||
        (target_o == pc_i && !push_o && !pop_o && !ime_set_o && sp_next_o == sp_i));
      assert_push_sp_R4: assert (!push_o || sp_next_o == sp_i - TWO);
      assert_pop_sp_R5: assert (!pop_o || sp_next_o == sp_i + TWO);
      assert_ime_reti_R6: assert (!ime_set_o || (pop_o && kind_i == 3'd4));
      assert_rst_vector_R7: assert (kind_i != 3'd5 ||
        (taken_o && push_o && target_o[2:0] == 3'b000 &&
         (target_o >> VEC_W) == '0 && cycles_o == 5'd16));
      assert_reg_jump_R8: assert (kind_i != 3'd6 ||
        (taken_o && target_o == hl_i && cycles_o == 5'd4 && !push_o && !pop_o));
      assert_reserved_R10: assert (kind_i != 3'd7 || (!taken_o && cycles_o == 5'd4));
    end
  end
endmodule

bind branch_eval branch_eval_chk #(.ADDR_W(ADDR_W), .RST_W(RST_W)) u_chk (
  .kind_i   (kind_i),
  .pc_i     (pc_i),
  .hl_i     (hl_i),
  .sp_i     (sp_i),
  .taken_o  (taken_o),
  .target_o (target_o),
  .cycles_o (cycles_o),
  .push_o   (push_o),
  .pop_o    (pop_o),
  .ime_set_o(ime_set_o),
  .sp_next_o(sp_next_o)
);

// File: tb/branch_eval_tb.sv
module branch_eval_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [2:0]  kind;
  logic        cond_en;
  logic [1:0]  cond;
  logic        fz, fc;
  logic [15:0] pc, imm, hl, stk, sp;
  logic [7:0]  disp;
  logic [2:0]  ridx;
  logic        taken_o, push_o, pop_o, ime_o;
  logic [15:0] target_o, sp_next_o;
  logic [4:0]  cycles_o;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  branch_eval u_dut (
    .kind_i(kind), .cond_en_i(cond_en), .cond_i(cond), .flag_z_i(fz), .flag_c_i(fc),
    .pc_i(pc), .disp_i(disp), .imm_i(imm), .hl_i(hl), .stack_data_i(stk),
    .rst_idx_i(ridx), .sp_i(sp), .taken_o(taken_o), .target_o(target_o),
    .cycles_o(cycles_o), .push_o(push_o), .pop_o(pop_o), .ime_set_o(ime_o),
    .sp_next_o(sp_next_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(logic [2:0] k);
    case (k)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R10";
    endcase
  endfunction

  // R1 condition meaning
  function automatic bit cond_holds(logic [1:0] c, logic z, logic cy);
    case (c)
      2'd0: return !z;
      2'd1: return z;
      2'd2: return !cy;
      default: return cy;
    endcase
  endfunction

  task automatic apply_and_check();
    bit exp_t;
    logic [15:0] exp_tgt, exp_sp;
    int exp_cyc;
    bit exp_push, exp_pop, exp_ime;
    string rq;
    @(posedge clk);
    #0.5;
    @(negedge clk);
    rq = req_of(kind);
    if (kind == 3'd7) exp_t = 0;
    else if (kind <= 3'd3 && cond_en) exp_t = cond_holds(cond, fz, fc);
    else exp_t = 1;
    exp_tgt = pc; exp_push = 0; exp_pop = 0; exp_ime = 0;
    case (kind)
      3'd0: exp_cyc = exp_t ? 16 : 12;
      3'd1: exp_cyc = exp_t ? 12 : 8;
      3'd2: exp_cyc = exp_t ? 24 : 12;
      3'd3: exp_cyc = !cond_en ? 16 : (exp_t ? 20 : 8);
      3'd4: exp_cyc = 16;
      3'd5: exp_cyc = 16;
      default: exp_cyc = 4;
    endcase
    if (exp_t) begin
      case (kind)
        3'd0: exp_tgt = imm;
        3'd1: exp_tgt = pc + {{8{disp[7]}}, disp};
        3'd2: begin exp_tgt = imm; exp_push = 1; end
        3'd3: begin exp_tgt = stk; exp_pop = 1; end
        3'd4: begin exp_tgt = stk; exp_pop = 1; exp_ime = 1; end
        3'd5: begin exp_tgt = {10'd0, ridx, 3'd0}; exp_push = 1; end
        3'd6: exp_tgt = hl;
        default: ;
      endcase
    end
    exp_sp = exp_push ? sp - 16'd2 : (exp_pop ? sp + 16'd2 : sp);
    if (kind <= 3'd3 && cond_en) chk("R1", "taken", int'(taken_o), int'(exp_t));
    else chk(rq, "taken", int'(taken_o), int'(exp_t));
    if (!exp_t) rq = (kind == 3'd7) ? "R10" : "R9";
    chk(rq, "target", int'(target_o), int'(exp_tgt));
    chk(req_of(kind), "cycles", int'(cycles_o), exp_cyc);
    chk(rq, "push", int'(push_o), int'(exp_push));
    chk(rq, "pop", int'(pop_o), int'(exp_pop));
    chk(rq, "ime", int'(ime_o), int'(exp_ime));
    chk(rq, "sp_next", int'(sp_next_o), int'(exp_sp));
  endtask

  task automatic rand_ops();
    pc = 16'($urandom); imm = 16'($urandom); hl = 16'($urandom);
    stk = 16'($urandom); sp = 16'($urandom); disp = 8'($urandom);
    ridx = 3'($urandom);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    kind = 3'd7; cond_en = 0; cond = 0; fz = 0; fc = 0;
    pc = 16'h1234; imm = 0; hl = 0; stk = 0; sp = 16'hFFFE; disp = 0; ridx = 0;
    // reset-like idle state: reserved kind, R10
    apply_and_check();

    // exhaustive sweep of kind x form x cond x flags (R1..R10)
    for (int k = 0; k < 8; k++)
      for (int e = 0; e < 2; e++)
        for (int c = 0; c < 4; c++)
          for (int f = 0; f < 4; f++) begin
            rand_ops();
            kind = 3'(k); cond_en = e[0]; cond = 2'(c); fz = f[1]; fc = f[0];
            apply_and_check();
          end

    // R3 wrap and sign extension corners
    kind = 3'd1; cond_en = 0;
    pc = 16'hFFFF; disp = 8'h01; apply_and_check();
    pc = 16'hFFFF; disp = 8'h7F; apply_and_check();
    pc = 16'h0000; disp = 8'h80; apply_and_check();
    pc = 16'h0000; disp = 8'hFF; apply_and_check();
    pc = 16'h8000; disp = 8'h80; apply_and_check();
    // R7 vector end points
    kind = 3'd5; ridx = 3'd0; apply_and_check();
    ridx = 3'd7; apply_and_check();
    // R4/R5 stack pointer wrap
    kind = 3'd2; cond_en = 0; sp = 16'h0001; apply_and_check();
    kind = 3'd3; sp = 16'hFFFF; apply_and_check();

    // random mix
    for (int i = 0; i < 3000; i++) begin
      rand_ops();
      kind = 3'($urandom); cond_en = 1'($urandom); cond = 2'($urandom);
      fz = 1'($urandom); fc = 1'($urandom);
      apply_and_check();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule